// File: doc/BRIEF.md
# Dual-Slope PWM Compare Output Unit

This block produces up to three pulse-width-modulated waveforms from a single up/down counter. The counter climbs from zero to a ceiling value, then descends back to zero, and repeats. The counter value and the sizes of these steps are the same for all channels. Each of the three channels compares its own threshold against the counter. A small per-channel mode field decides how a match moves that channel's output pin: leave the pin to the normal port, toggle it, or drive it low or high depending on the direction the counter was moving at the match.

A 4-bit waveform mode selects one of four dual-slope variants. The variants differ in where the ceiling comes from, either a dedicated ceiling input or channel A's threshold. They also differ in when the double-buffered thresholds are refreshed, either at the bottom or at the top of the ramp. Every other waveform mode parks the counter and releases all pins. The counter advances only on cycles where the prescaled tick input is high. Each pin has an enable flag that tells the port logic whether the waveform replaces normal port behaviour.

Top module: `dspwm_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, all three wave outputs are 0.
- R2: When `wgm` is not 8, 9, 10 or 11, the counter is parked at zero with its next step upward. All three `oe_*` flags are 0, and the threshold buffers copy their inputs on every clock.
- R3: In modes 8 to 11 the counter changes only on cycles with `tick` high. Its sequence is 0,1,…,TOP,TOP-1,…,1,0,1,…, so TOP and zero each last exactly one tick. If TOP is zero, the counter stays at zero.
- R4: Modes 8 and 10 (`wgm[0]`=0) take TOP from `top_val`. Modes 9 and 11 (`wgm[0]`=1) take TOP from the buffered channel A threshold.
- R5: The threshold buffers are loaded from `cmp_*` on a tick at which the counter is at zero in modes 8 and 9 (`wgm[1]`=0), or at TOP in modes 10 and 11 (`wgm[1]`=1). At all other times they hold.
- R6: A channel whose `com_*` field is 00 has its `oe` flag at 0 and its wave output unchanged.
- R7: With `com_a`=01 in modes 8 to 11, `wave_a` inverts on every match and `oe_a` is 1. With 01 on channel B or C, or with 01 in any other mode, that channel's `oe` is 0 and its wave is unchanged.
- R8: With `com`=10, a match away from TOP and zero drives the wave to 0 while counting up and to 1 while counting down.
- R9: With `com`=11, a match away from TOP and zero drives the wave to 1 while counting up and to 0 while counting down.
- R10: A match at TOP forces the wave to 1 for `com`=10 and to 0 for `com`=11. This rule takes priority over R11 when TOP is zero, and a threshold equal to TOP therefore gives a steady level.
- R11: A match at zero forces the wave to 0 for `com`=10 and to 1 for `com`=11, which gives the opposite steady level.
- R12: A match is a tick on which the counter equals the channel's buffered threshold. The wave changes at that clock edge and at no other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count enable |
| wgm | input | 4 | Waveform mode; 8 to 11 are dual-slope |
| com_a | input | 2 | Output mode, channel A |
| com_b | input | 2 | Output mode, channel B |
| com_c | input | 2 | Output mode, channel C |
| cmp_a | input | CNT_W | Threshold A (also TOP in modes 9 and 11) |
| cmp_b | input | CNT_W | Threshold B |
| cmp_c | input | CNT_W | Threshold C |
| top_val | input | CNT_W | TOP in modes 8 and 10 |
| wave_a | output | 1 | Waveform, channel A |
| wave_b | output | 1 | Waveform, channel B |
| wave_c | output | 1 | Waveform, channel C |
| oe_a | output | 1 | Channel A overrides port |
| oe_b | output | 1 | Channel B overrides port |
| oe_c | output | 1 | Channel C overrides port |

## Verification
The sweep drives thresholds equal to TOP and equal to zero, where a design that used plain direction rules would emit a one-tick glitch instead of a steady level. It moves thresholds in the middle of a ramp, so that a design refreshing its buffers at the wrong end, or not buffering at all, produces an asymmetric pulse. Toggle mode is applied to all three channels and outside modes 8 to 11, which exposes a design that lets B or C or an idle mode grab the pin. A gated tick pattern catches a counter that steps freely or that dwells two ticks at an extreme.

// File: rtl/dspwm_pkg.sv
package dspwm_pkg;

  localparam int unsigned NUM_CH = 3;

  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } dir_e;

  typedef enum logic [1:0] {
    COM_OFF   = 2'b00,
    COM_TGL   = 2'b01,
    COM_LO_UP = 2'b10,
    COM_HI_UP = 2'b11
  } com_e;

  function automatic logic wgm_is_dual(input logic [3:0] w);
    return w[3:2] == 2'b10;
  endfunction

  function automatic logic wgm_top_from_a(input logic [3:0] w);
    return w[0];
  endfunction

  function automatic logic wgm_load_at_top(input logic [3:0] w);
    return w[1];
  endfunction

endpackage

// File: rtl/dspwm_counter.sv
module dspwm_counter
  import dspwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             active,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt,
  output dir_e             dir,
  output logic             at_top,
  output logic             at_bot
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  dir_e             dir_q, dir_d;

  assign at_top = (cnt_q == top);
  assign at_bot = (cnt_q == '0);
  assign cnt    = cnt_q;
  assign dir    = dir_q;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (!active) begin
      cnt_d = '0;
      dir_d = DIR_DN;
    end else if (tick) begin
      if (top == '0) begin
        cnt_d = '0;
        dir_d = DIR_DN;
      end else if (dir_q == DIR_UP) begin
        if (cnt_q < top) begin
          cnt_d = cnt_q + 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
          dir_d = DIR_DN;
        end
      end else begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
          dir_d = DIR_UP;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_DN;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  AST_IDLE_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt_q == '0 && dir_q == DIR_DN)); // R2
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> $stable(cnt_q)); // R3
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick && top != '0) |=> (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == $past(cnt_q) - 1'b1)); // R3
  AST_TOP_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick && at_top && top != '0) |=> (dir_q == DIR_DN)); // R3
  AST_BOT_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick && at_bot && top != '0) |=> (dir_q == DIR_UP && cnt_q == 1)); // R3

endmodule

// File: rtl/dspwm_cmp_buf.sv
module dspwm_cmp_buf #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] din,
  output logic [CNT_W-1:0] dout
);

  logic [CNT_W-1:0] buf_q, buf_d;

  always_comb begin
    buf_d = buf_q;
    if (load) buf_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_q <= '0;
    else        buf_q <= buf_d;
  end

  assign dout = buf_q;

endmodule

// File: rtl/dspwm_out_chan.sv
module dspwm_out_chan
  import dspwm_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter bit          TGL_OK = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             active,
  input  logic [1:0]       com,
  input  logic [CNT_W-1:0] cmp,
  input  logic [CNT_W-1:0] cnt,
  input  dir_e             dir,
  input  logic             at_top,
  input  logic             at_bot,
  output logic             wave,
  output logic             oe
);

  logic wave_q, wave_d;
  logic match;
  logic tgl_sel;

  assign match   = active && tick && (cnt == cmp);
  assign tgl_sel = TGL_OK && (com == COM_TGL);
  assign oe      = active && (com[1] || tgl_sel);

  always_comb begin
    wave_d = wave_q;
    if (match) begin
      case (com)
        COM_TGL: begin
          if (TGL_OK) wave_d = ~wave_q;
        end
        COM_LO_UP: begin
          if (at_top)      wave_d = 1'b1;
          else if (at_bot) wave_d = 1'b0;
          else             wave_d = (dir == DIR_DN);
        end
        COM_HI_UP: begin
          if (at_top)      wave_d = 1'b0;
          else if (at_bot) wave_d = 1'b1;
          else             wave_d = (dir == DIR_UP);
        end
        default: wave_d = wave_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_d;
  end

  assign wave = wave_q;

  AST_WAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !match |=> $stable(wave_q)); // R12
  AST_TOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (match && at_top && com == COM_LO_UP) |=> wave_q); // R10
  AST_TOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (match && at_top && com == COM_HI_UP) |=> !wave_q); // R10
  AST_BOT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !at_top && at_bot && com == COM_LO_UP) |=> !wave_q); // R11
  AST_UP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !at_top && !at_bot && dir == DIR_UP && com == COM_LO_UP) |=> !wave_q); // R8
  AST_DN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !at_top && !at_bot && dir == DIR_DN && com == COM_HI_UP) |=> !wave_q); // R9
  AST_OFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (com == COM_OFF) |-> !oe); // R6

  if (TGL_OK) begin : g_tgl
    AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (match && com == COM_TGL) |=> (wave_q != $past(wave_q))); // R7
  end else begin : g_no_tgl
    AST_TGL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (com == COM_TGL) |=> $stable(wave_q)); // R7
  end

endmodule

// File: rtl/dspwm_unit.sv
module dspwm_unit
  import dspwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [3:0]       wgm,
  input  logic [1:0]       com_a,
  input  logic [1:0]       com_b,
  input  logic [1:0]       com_c,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [CNT_W-1:0] cmp_c,
  input  logic [CNT_W-1:0] top_val,
  output logic             wave_a,
  output logic             wave_b,
  output logic             wave_c,
  output logic             oe_a,
  output logic             oe_b,
  output logic             oe_c
);

  logic             active;
  logic [CNT_W-1:0] top_sel;
  logic [CNT_W-1:0] cnt;
  dir_e             dir;
  logic             at_top, at_bot;
  logic             reload;

  logic [CNT_W-1:0] cmp_in [NUM_CH];
  logic [CNT_W-1:0] cmp_q  [NUM_CH];
  logic [1:0]       com_v  [NUM_CH];
  logic             wave_v [NUM_CH];
  logic             oe_v   [NUM_CH];

  assign cmp_in[0] = cmp_a;
  assign cmp_in[1] = cmp_b;
  assign cmp_in[2] = cmp_c;
  assign com_v[0]  = com_a;
  assign com_v[1]  = com_b;
  assign com_v[2]  = com_c;

  assign active  = wgm_is_dual(wgm);
  assign top_sel = wgm_top_from_a(wgm) ? cmp_q[0] : top_val;
  assign reload  = !active || (tick && (wgm_load_at_top(wgm) ? at_top : at_bot));

  dspwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .active (active),
    .top    (top_sel),
    .cnt    (cnt),
    .dir    (dir),
    .at_top (at_top),
    .at_bot (at_bot)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dspwm_cmp_buf #(.CNT_W(CNT_W)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (reload),
      .din   (cmp_in[i]),
      .dout  (cmp_q[i])
    );

    dspwm_out_chan #(.CNT_W(CNT_W), .TGL_OK(i == 0)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .active (active),
      .com    (com_v[i]),
      .cmp    (cmp_q[i]),
      .cnt    (cnt),
      .dir    (dir),
      .at_top (at_top),
      .at_bot (at_bot),
      .wave   (wave_v[i]),
      .oe     (oe_v[i])
    );

    AST_BUF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !(wgm_load_at_top(wgm) ? at_top : at_bot)) |=> $stable(cmp_q[i])); // R5
  end

  assign wave_a = wave_v[0];
  assign wave_b = wave_v[1];
  assign wave_c = wave_v[2];
  assign oe_a   = oe_v[0];
  assign oe_b   = oe_v[1];
  assign oe_c   = oe_v[2];

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !(oe_a || oe_b || oe_c)); // R2
  AST_BC_NO_TGL: assert property (@(posedge clk) disable iff (!rst_n)
    (com_b == COM_TGL) |-> !oe_b); // R7
  AST_RESET_LOW: assert property (@(posedge clk)
    $rose(rst_n) |-> !(wave_a || wave_b || wave_c)); // R1

endmodule

// File: tb/dspwm_unit_tb_top.sv
module dspwm_unit_tb_top;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         tick;
  logic [3:0]   wgm;
  logic [1:0]   com_a, com_b, com_c;
  logic [W-1:0] cmp_a, cmp_b, cmp_c, top_val;
  logic         wave_a, wave_b, wave_c, oe_a, oe_b, oe_c;

  int    total = 0;
  int    bad   = 0;
  int    cyc   = 0;
  bit    chk_en = 1'b0;
  bit    gate   = 1'b0;
  string phase  = "R1";

  logic [W-1:0] m_cnt;
  logic         m_dir;
  logic [W-1:0] m_buf [3];
  logic         m_wave[3];
  logic         m_dual, m_atop, m_abot, m_load;
  logic [W-1:0] m_top;

  always #10 clk = ~clk;

  dspwm_unit #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wgm(wgm),
    .com_a(com_a), .com_b(com_b), .com_c(com_c),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c), .top_val(top_val),
    .wave_a(wave_a), .wave_b(wave_b), .wave_c(wave_c),
    .oe_a(oe_a), .oe_b(oe_b), .oe_c(oe_c)
  );

  function automatic logic [1:0] com_of(input int ch);
    return (ch == 0) ? com_a : (ch == 1) ? com_b : com_c;
  endfunction

  function automatic logic [W-1:0] cmp_of(input int ch);
    return (ch == 0) ? cmp_a : (ch == 1) ? cmp_b : cmp_c;
  endfunction

  function automatic string com_tag(input logic [1:0] c);
    case (c)
      2'b00:   return "R6";
      2'b01:   return "R7";
      2'b10:   return "R8";
      default: return "R9";
    endcase
  endfunction

  // Reference model of counter, buffers and pins (R2..R5, R7..R12)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0;
      m_dir = 1'b1;
      for (int i = 0; i < 3; i++) begin
        m_buf[i]  = '0;
        m_wave[i] = 1'b0;
      end
    end else begin
      m_dual = (wgm[3:2] == 2'b10);
      m_top  = wgm[0] ? m_buf[0] : top_val;
      m_atop = (m_cnt == m_top);
      m_abot = (m_cnt == '0);
      if (!m_dual) begin
        m_cnt = '0;
        m_dir = 1'b1;
        for (int i = 0; i < 3; i++) m_buf[i] = cmp_of(i);
      end else if (tick) begin
        for (int i = 0; i < 3; i++) begin
          if (m_cnt == m_buf[i]) begin
            case (com_of(i))
              2'b01: if (i == 0) m_wave[i] = ~m_wave[i];
              2'b10: m_wave[i] = m_atop ? 1'b1 : m_abot ? 1'b0 : m_dir;
              2'b11: m_wave[i] = m_atop ? 1'b0 : m_abot ? 1'b1 : ~m_dir;
              default: ;
            endcase
          end
        end
        m_load = wgm[1] ? m_atop : m_abot;
        if (m_load) for (int i = 0; i < 3; i++) m_buf[i] = cmp_of(i);
        if (m_top == '0) begin
          m_cnt = '0;
          m_dir = 1'b1;
        end else if (!m_dir) begin
          if (m_cnt < m_top) m_cnt = m_cnt + 1'b1;
          else begin m_cnt = m_cnt - 1'b1; m_dir = 1'b1; end
        end else begin
          if (m_cnt != '0) m_cnt = m_cnt - 1'b1;
          else begin m_cnt = m_cnt + 1'b1; m_dir = 1'b0; end
        end
      end
    end
  end

  task automatic check_pin(input int ch, input logic act_w, input logic act_oe);
    logic [1:0] c;
    logic       exp_oe;
    c      = com_of(ch);
    exp_oe = (wgm[3:2] == 2'b10) && (c[1] || (ch == 0 && c == 2'b01));
    total++;
    if (act_w !== m_wave[ch]) begin
      bad++;
      $display("FAIL %s/%s ch%0d wave act=%0b exp=%0b t=%0t", phase, com_tag(c), ch, act_w, m_wave[ch], $time);
    end
    total++;
    if (act_oe !== exp_oe) begin
      bad++;
      $display("FAIL %s/%s ch%0d oe act=%0b exp=%0b t=%0t", phase,
               (wgm[3:2] == 2'b10) ? com_tag(c) : "R2", ch, act_oe, exp_oe, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      check_pin(0, wave_a, oe_a);
      check_pin(1, wave_b, oe_b);
      check_pin(2, wave_c, oe_c);
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2 tick = !(gate && (cyc % 3 == 1));
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic run_case(input logic [3:0] m, input logic [1:0] ca, input logic [1:0] cb,
                          input logic [1:0] cc, input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [W-1:0] c, input int n);
    wgm = 4'd0;
    com_a = ca; com_b = cb; com_c = cc;
    cmp_a = a; cmp_b = b; cmp_c = c;
    step(2);
    wgm = m;
    step(n);
  endtask

  initial begin
    rst_n = 1'b0;
    tick = 1'b1;
    wgm = 4'd0;
    com_a = 2'b00; com_b = 2'b00; com_c = 2'b00;
    cmp_a = '0; cmp_b = '0; cmp_c = '0;
    top_val = 16'd6;
    repeat (3) @(negedge clk);
    // R1: pins low while in reset
    total++;
    if ({wave_a, wave_b, wave_c} !== 3'b000) begin
      bad++;
      $display("FAIL R1 reset wave act=%b exp=000", {wave_a, wave_b, wave_c});
    end
    @(posedge clk); #2 rst_n = 1'b1;
    chk_en = 1'b1;
    step(2);

    // R2: idle modes release pins and keep waves
    phase = "R2 idle";
    foreach (wgm[i]) ;
    for (int m = 0; m < 16; m++) begin
      if (m >= 8 && m <= 11) continue;
      run_case(4'(m), 2'b01, 2'b10, 2'b11, 16'd2, 16'd3, 16'd0, 6);
    end

    // Full sweep of modes, output-mode rotations and threshold patterns
    for (int pat = 0; pat < 4; pat++) begin
      for (int m = 8; m < 12; m++) begin
        for (int k = 0; k < 4; k++) begin
          logic [W-1:0] pa, pb, pc;
          case (pat)
            0: begin pa = 16'd6; pb = 16'd2; pc = 16'd4; phase = "R4/R12 sweep"; end
            1: begin pa = 16'd6; pb = 16'd0; pc = 16'd6; phase = "R10/R11 edge"; end
            2: begin pa = 16'd3; pb = 16'd6; pc = 16'd1; phase = "R4 top source"; end
            default: begin pa = 16'd5; pb = 16'd5; pc = 16'd0; phase = "R10/R11 edge"; end
          endcase
          run_case(4'(m), 2'(k), 2'(k + 1), 2'(k + 2), pa, pb, pc, 40);
        end
      end
    end

    // R3: gated tick
    phase = "R3 gated";
    gate = 1'b1;
    for (int m = 8; m < 12; m++) begin
      run_case(4'(m), 2'b10, 2'b11, 2'b10, 16'd4, 16'd1, 16'd3, 50);
    end
    gate = 1'b0;

    // R5: thresholds move in the middle of a ramp
    phase = "R5 reload";
    for (int m = 8; m < 12; m++) begin
      run_case(4'(m), 2'b10, 2'b11, 2'b10, 16'd6, 16'd2, 16'd4, 9);
      cmp_b = 16'd4; cmp_c = 16'd1;
      step(7);
      cmp_a = 16'd5; cmp_b = 16'd3;
      step(30);
    end

    // R3: TOP of zero keeps the counter at zero
    phase = "R3 top zero";
    top_val = 16'd0;
    run_case(4'd8, 2'b10, 2'b11, 2'b10, 16'd0, 16'd0, 16'd1, 12);
    run_case(4'd10, 2'b11, 2'b10, 2'b11, 16'd0, 16'd0, 16'd1, 12);
    top_val = 16'd6;

    chk_en = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule